// File: doc/BRIEF.md
# Atomic Read-Modify-Write Completer

This block sits in front of a local memory and services atomic requests that arrive from elsewhere in the system. Three operations are supported: fetch-and-add, unconditional swap and compare-and-swap. Operands may be 32, 64 or 128 bits wide. Each request is carried out indivisibly. The old line is read, the operand lane is changed and the line is written back before the next request is accepted. Every request produces exactly one completion. That completion echoes the requester tag, carries a status code, and holds the value the target had before the operation.

Requests enter on a valid/ready channel. A request carries an opcode, a size code, a byte address, two operands and a tag. Completions leave on a second valid/ready channel. The memory is an internal array of 128-bit lines, and a byte address selects a line and a byte offset within it. Bad requests are answered with an error status and never reach the memory. A request is bad if it uses an unknown opcode, an unknown size code or a width that is switched off at the configuration input, or if its address is not aligned to its operand size.

Top module: `atomic_completer`

## Requirements
- R1: Fetch-and-add (opcode 0) returns the old operand and stores (old + req_opa) modulo 2^width, discarding the carry.
- R2: Swap (opcode 1) returns the old operand and stores req_opa unconditionally.
- R3: Compare-and-swap (opcode 2) returns the old operand and stores req_opb only when the old operand equals req_opa; otherwise memory is unchanged.
- R4: Size codes 0, 1 and 2 select 32, 64 and 128-bit operands. Bits [3:0] of the address give the byte offset within a 128-bit line, lanes are little-endian, operands and returned data are right-aligned and zero-extended, and no byte outside the addressed operand changes.
- R5: A request whose address is not a multiple of the operand size in bytes completes with status 3'b100, data zero, and no memory change.
- R6: Each misaligned request raises err_pulse for exactly one cycle. No other request raises it.
- R7: A request with opcode 3, size code 3, or a size whose cfg_size_en bit (bit 0 = 32, bit 1 = 64, bit 2 = 128) is clear completes with status 3'b001, data zero, and no memory change or error pulse. This check takes precedence over the alignment check.
- R8: Each accepted request yields exactly one completion, in request order, with its tag echoed. Successful operations carry status 3'b000. req_ready is low from acceptance until the completion handshake.
- R9: While cpl_valid is high and cpl_ready is low, the completion fields stay constant.
- R10: After synchronous reset, req_ready is 1 and both cpl_valid and err_pulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size_en | input | 3 | Enabled operand widths (bit 0 = 32, bit 1 = 64, bit 2 = 128) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can accept a request |
| req_op | input | 2 | 0 add, 1 swap, 2 compare-and-swap |
| req_size | input | 2 | 0 = 32, 1 = 64, 2 = 128 bits |
| req_addr | input | ADDR_W | Byte address of the target |
| req_opa | input | 128 | Addend, swap value or compare value |
| req_opb | input | 128 | Swap value for compare-and-swap |
| req_tag | input | TAG_W | Requester tag |
| cpl_valid | output | 1 | Completion present |
| cpl_ready | input | 1 | Completion taken |
| cpl_tag | output | TAG_W | Echoed tag |
| cpl_status | output | 3 | 000 success, 001 unsupported, 100 abort |
| cpl_data | output | 128 | Pre-operation value, zero-extended |
| err_pulse | output | 1 | One-cycle pulse on a misaligned request |

## Verification
The bench builds the engine with DEPTH = 4 lines and TAG_W = 6. This makes the memory only 64 bytes, so a byte-level model covers all of it. The bench visits every aligned position of every width on every line with all three operations, including compare hits, compare misses and an add that wraps. It also sweeps every misaligned offset for each width. It then turns off each width in turn and checks the unsupported codes. A final full read-back shows that no rejected request and no lane write disturbed neighbouring bytes.

// File: rtl/atom_pkg.sv
package atom_pkg;
  localparam int LINE_W = 128;
  localparam int OFF_W  = 4;

  localparam logic [1:0] OP_FADD = 2'd0;
  localparam logic [1:0] OP_SWAP = 2'd1;
  localparam logic [1:0] OP_CAS  = 2'd2;

  localparam logic [1:0] SZ_32  = 2'd0;
  localparam logic [1:0] SZ_64  = 2'd1;
  localparam logic [1:0] SZ_128 = 2'd2;

  localparam logic [2:0] ST_OK = 3'b000;
  localparam logic [2:0] ST_UR = 3'b001;
  localparam logic [2:0] ST_CA = 3'b100;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_EXE, S_CPL} cstate_t;
endpackage

// File: rtl/atom_decode.sv
module atom_decode import atom_pkg::*; (
  input  logic [1:0]       op,
  input  logic [1:0]       size,
  input  logic [OFF_W-1:0] off,
  input  logic [2:0]       size_en,
  output logic [2:0]       status
);
  logic             size_ok;
  logic [OFF_W-1:0] low_mask;

  always_comb begin
    unique case (size)
      SZ_32:   begin size_ok = size_en[0]; low_mask = 4'h3; end
      SZ_64:   begin size_ok = size_en[1]; low_mask = 4'h7; end
      SZ_128:  begin size_ok = size_en[2]; low_mask = 4'hF; end
      default: begin size_ok = 1'b0;       low_mask = 4'h0; end
    endcase
    if (!size_ok || op == 2'd3)
      status = ST_UR;
    else if (|(off & low_mask))
      status = ST_CA;
    else
      status = ST_OK;
  end
endmodule

// File: rtl/atom_alu.sv
module atom_alu import atom_pkg::*; (
  input  logic [LINE_W-1:0] line,
  input  logic [1:0]        op,
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  input  logic [LINE_W-1:0] opa,
  input  logic [LINE_W-1:0] opb,
  output logic [LINE_W-1:0] new_line,
  output logic [LINE_W-1:0] old_val
);
  logic [LINE_W-1:0] wmask;
  logic [LINE_W-1:0] res;
  logic [6:0]        shift;

  always_comb begin
    shift = {off, 3'b000};
    unique case (size)
      SZ_32:   wmask = {{(LINE_W-32){1'b0}}, {32{1'b1}}};
      SZ_64:   wmask = {{(LINE_W-64){1'b0}}, {64{1'b1}}};
      default: wmask = {LINE_W{1'b1}};
    endcase
    old_val = (line >> shift) & wmask;
    unique case (op)
      OP_FADD: res = (old_val + opa) & wmask;
      OP_SWAP: res = opa & wmask;
      OP_CAS:  res = (old_val == (opa & wmask)) ? (opb & wmask) : old_val;
      default: res = old_val;
    endcase
    new_line = (line & ~(wmask << shift)) | (res << shift);
  end
endmodule

// File: rtl/atom_mem.sv
module atom_mem #(
  parameter int LINE_W = 128,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [LINE_W-1:0] rd_data,
  input  logic              we,
  input  logic [AW-1:0]     wr_addr,
  input  logic [LINE_W-1:0] wr_data
);
  logic [LINE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[wr_addr] <= wr_data;
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/atomic_completer.sv
module atomic_completer import atom_pkg::*; #(
  parameter int DEPTH   = 256,
  parameter int TAG_W   = 8,
  localparam int LINE_AW = $clog2(DEPTH),
  localparam int ADDR_W  = LINE_AW + OFF_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_size_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LINE_W-1:0] req_opa,
  input  logic [LINE_W-1:0] req_opb,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic [2:0]        cpl_status,
  output logic [LINE_W-1:0] cpl_data,
  output logic              err_pulse
);
  cstate_t              state;
  logic [1:0]           op_q, size_q;
  logic [OFF_W-1:0]     off_q;
  logic [LINE_AW-1:0]   line_q;
  logic [LINE_W-1:0]    opa_q, opb_q;
  logic [2:0]           dec_status;
  logic [LINE_W-1:0]    rd_line, new_line, old_val;
  logic                 mem_we, mem_re;

  atom_decode u_dec (
    .op(req_op), .size(req_size), .off(req_addr[OFF_W-1:0]),
    .size_en(cfg_size_en), .status(dec_status)
  );

  assign mem_we = (state == S_EXE);
  assign mem_re = (state == S_RD);

  atom_mem #(.LINE_W(LINE_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rd_en(mem_re), .rd_addr(line_q), .rd_data(rd_line),
    .we(mem_we), .wr_addr(line_q), .wr_data(new_line)
  );

  atom_alu u_alu (
    .line(rd_line), .op(op_q), .size(size_q), .off(off_q),
    .opa(opa_q), .opb(opb_q), .new_line(new_line), .old_val(old_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      err_pulse  <= 1'b0;
      cpl_status <= ST_OK;
      cpl_data   <= '0;
      cpl_tag    <= '0;
      op_q       <= '0;
      size_q     <= '0;
      off_q      <= '0;
      line_q     <= '0;
      opa_q      <= '0;
      opb_q      <= '0;
    end else begin
      err_pulse <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          op_q    <= req_op;
          size_q  <= req_size;
          off_q   <= req_addr[OFF_W-1:0];
          line_q  <= req_addr[ADDR_W-1:OFF_W];
          opa_q   <= req_opa;
          opb_q   <= req_opb;
          cpl_tag <= req_tag;
          if (dec_status != ST_OK) begin
            cpl_status <= dec_status;
            cpl_data   <= '0;
            err_pulse  <= (dec_status == ST_CA);
            state      <= S_CPL;
          end else begin
            state <= S_RD;
          end
        end
        S_RD:  state <= S_EXE;
        S_EXE: begin
          cpl_status <= ST_OK;
          cpl_data   <= old_val;
          state      <= S_CPL;
        end
        S_CPL: if (cpl_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign cpl_valid = (state == S_CPL);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  // R9
  cpl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_data)
      && $stable(cpl_tag) && $stable(cpl_status));

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !err_pulse);

  // R5
  err_abort_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> cpl_valid && cpl_status == ST_CA);

  // R7
  write_ok_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> cpl_valid && cpl_status == ST_OK);
endmodule

// File: tb/test_atomic_completer.sv
`timescale 1ns/1ps
module test_atomic_completer;
  localparam int DEPTH = 4;
  localparam int TAG_W = 6;
  localparam int NB    = DEPTH * 16;
  localparam int AW    = $clog2(DEPTH) + 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst;
  logic [2:0]        cfg_size_en;
  logic              req_valid, req_ready;
  logic [1:0]        req_op, req_size;
  logic [AW-1:0]     req_addr;
  logic [127:0]      req_opa, req_opb;
  logic [TAG_W-1:0]  req_tag;
  logic              cpl_valid, cpl_ready;
  logic [TAG_W-1:0]  cpl_tag;
  logic [2:0]        cpl_status;
  logic [127:0]      cpl_data;
  logic              err_pulse;

  atomic_completer #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_atomic_completer (
    .clk(clk), .rst(rst), .cfg_size_en(cfg_size_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_size(req_size), .req_addr(req_addr), .req_opa(req_opa),
    .req_opb(req_opb), .req_tag(req_tag), .cpl_valid(cpl_valid),
    .cpl_ready(cpl_ready), .cpl_tag(cpl_tag), .cpl_status(cpl_status),
    .cpl_data(cpl_data), .err_pulse(err_pulse)
  );

  int checks = 0, errors = 0, err_seen = 0, cyc = 0, seed = 1;
  logic [7:0] mb [NB];
  logic [TAG_W-1:0] tag_ctr = '0;

  always @(posedge clk) begin
    if (!rst && err_pulse) err_seen++;
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R8 watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [127:0] get_old(input int addr, input int sz);
    logic [127:0] v = '0;
    for (int i = 0; i < (4 << sz); i++) v[i*8 +: 8] = mb[addr + i];
    return v;
  endfunction

  function automatic logic [127:0] mix(input int s);
    logic [31:0] u = s;
    return {u * 32'h9E3779B9, u * 32'h85EBCA6B ^ 32'h5A5A1234,
            u * 32'hC2B2AE35 + 32'h0F0F0F0F, u * 32'h27D4EB2F ^ 32'hFFFF0000};
  endfunction

  task automatic do_req(input logic [1:0] op, input logic [1:0] sz, input int addr,
                        input logic [127:0] a, input logic [127:0] b,
                        input logic [2:0] est, input string rq, input int stall, input bit ck);
    logic [127:0] mk, old, nv, exp_data, hd;
    logic [TAG_W-1:0] ht;
    int exp_err;
    mk = (sz == 2'd2) ? {128{1'b1}} : ((128'd1 << (32 << sz)) - 128'd1);
    exp_data = '0;
    exp_err = err_seen + ((est == 3'b100) ? 1 : 0);
    if (est == 3'b000) begin
      old = get_old(addr, sz);
      exp_data = old;
      case (op)
        2'd0: nv = (old + a) & mk;
        2'd1: nv = a & mk;
        default: nv = (old == (a & mk)) ? (b & mk) : old;
      endcase
      for (int i = 0; i < (4 << sz); i++) mb[addr + i] = nv[i*8 +: 8];
    end
    req_valid = 1'b1; req_op = op; req_size = sz; req_addr = AW'(addr);
    req_opa = a; req_opb = b; req_tag = tag_ctr;
    while (!req_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, {rq, " R8 busy after accept"}, 128'(req_ready), 128'd0);
    while (!cpl_valid) @(negedge clk);
    for (int k = 0; k < stall; k++) begin
      hd = cpl_data; ht = cpl_tag;
      @(negedge clk);
      chk(cpl_valid && cpl_data == hd && cpl_tag == ht, "R9 hold under stall",
          cpl_data, hd);
    end
    chk(cpl_tag == tag_ctr, {rq, " R8 tag"}, 128'(cpl_tag), 128'(tag_ctr));
    chk(cpl_status == est, {rq, " status"}, 128'(cpl_status), 128'(est));
    if (ck) chk(cpl_data == exp_data, {rq, " old data"}, cpl_data, exp_data);
    cpl_ready = 1'b1;
    @(negedge clk);
    cpl_ready = 1'b0;
    chk(!cpl_valid && req_ready, "R8 single completion", 128'({cpl_valid, req_ready}), 128'd1);
    chk(err_seen == exp_err, {rq, " R6 error pulse count"}, 128'(err_seen), 128'(exp_err));
    tag_ctr++;
  endtask

  initial begin
    rst = 1'b1; cfg_size_en = 3'b111; req_valid = 1'b0; cpl_ready = 1'b0;
    req_op = '0; req_size = '0; req_addr = '0; req_opa = '0; req_opb = '0; req_tag = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !cpl_valid && !err_pulse, "R10 reset state",
        128'({req_ready, cpl_valid, err_pulse}), 128'b100);

    // initialise every line with a 128-bit swap (R2)
    for (int ln = 0; ln < DEPTH; ln++)
      do_req(2'd1, 2'd2, ln*16, mix(100 + ln), '0, 3'b000, "R2 init", 0, 1'b0);

    // full sweep over lines, widths and aligned lanes (R1 R2 R3 R4)
    for (int ln = 0; ln < DEPTH; ln++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 16; off += (4 << sz)) begin
          seed++;
          do_req(2'd0, 2'(sz), ln*16 + off, mix(seed), '0, 3'b000, "R1 add",
                 (seed % 5 == 0) ? 3 : 0, 1'b1);
          do_req(2'd2, 2'(sz), ln*16 + off, get_old(ln*16 + off, sz), mix(seed + 7),
                 3'b000, "R3 cas hit", 0, 1'b1);
          do_req(2'd2, 2'(sz), ln*16 + off, ~get_old(ln*16 + off, sz), mix(seed + 9),
                 3'b000, "R3 cas miss", (seed % 7 == 0) ? 2 : 0, 1'b1);
          do_req(2'd1, 2'(sz), ln*16 + off, mix(seed + 11), '0, 3'b000, "R2 swap", 0, 1'b1);
        end

    // wrap-around of fetch-and-add (R1)
    for (int sz = 0; sz < 3; sz++) begin
      do_req(2'd1, 2'(sz), 16, {128{1'b1}}, '0, 3'b000, "R1 wrap setup", 0, 1'b1);
      do_req(2'd0, 2'(sz), 16, 128'd2, '0, 3'b000, "R1 wrap add", 0, 1'b1);
      chk(get_old(16, sz) == 128'd1, "R1 wrap model", get_old(16, sz), 128'd1);
      do_req(2'd0, 2'(sz), 16, 128'd0, '0, 3'b000, "R1 wrap readback", 0, 1'b1);
    end

    // every misaligned offset per width (R5 R6)
    for (int sz = 0; sz < 3; sz++)
      for (int off = 1; off < 16; off++)
        if (off % (4 << sz) != 0) begin
          seed++;
          do_req(2'(seed % 3), 2'(sz), 32 + off, mix(seed), mix(seed + 1),
                 3'b100, "R5 misaligned", (seed % 4 == 0) ? 2 : 0, 1'b1);
        end

    // unsupported widths and codes (R7)
    for (int sz = 0; sz < 3; sz++) begin
      cfg_size_en = 3'b111 & ~(3'b001 << sz);
      do_req(2'd1, 2'(sz), 48, mix(seed + sz), '0, 3'b001, "R7 width disabled", 0, 1'b1);
    end
    cfg_size_en = 3'b111;
    do_req(2'd1, 2'd3, 0, mix(3), '0, 3'b001, "R7 size code 3", 0, 1'b1);
    do_req(2'd3, 2'd0, 0, mix(4), '0, 3'b001, "R7 opcode 3", 0, 1'b1);
    do_req(2'd3, 2'd1, 6, mix(5), '0, 3'b001, "R7 precedence over misalign", 0, 1'b1);

    // full read-back: nothing outside addressed lanes changed (R4 R5 R7)
    for (int ln = 0; ln < DEPTH; ln++)
      do_req(2'd0, 2'd2, ln*16, 128'd0, '0, 3'b000, "R4 readback", 0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule